// File: doc/BRIEF.md
# Second-Stage Page Table Walker

This block turns a guest physical address into a host physical address. It walks a multi-level translation hierarchy that belongs to the hypervisor. The hypervisor gives the root table base on `root_base`. The block then reads one 64-bit entry per level through a simple request/response table-read port. Each level is indexed by a 9-bit slice of the guest address. By default the hierarchy has four levels, which covers a 48-bit guest address. Setting `LEVELS` to 5 gives five levels and a 57-bit guest address.

A walk ends in one of three ways:
- at a 4 KB leaf on the lowest level;
- early, at a 2 MB or 1 GB large-page leaf;
- at a violation.

Every entry carries its own read, write and execute permission bits. These are separate from any guest-stage permission. The permission of the walk is the AND of those bits over every entry visited. When the walk finishes, the block pulses `done` for one cycle. If the walk failed, it also returns a violation record with the access-kind flags, the faulting guest address, the level and the effective permissions.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rd_valid` and `done` are 0.
- R2: A walk that ends at a level-1 leaf issues exactly `LEVELS` reads.
  - The read for level n goes to the current table frame, followed by guest address bits [12+9(n-1)+8 : 12+9(n-1)] as the index, followed by three zero bits.
  - The entry's frame field is bits [PA_W-1:12].
  - The result is that frame joined with guest address bits [11:0].
- R3: An entry at level 3 with bit 7 set ends the walk as a 1 GB leaf, with result {entry[PA_W-1:30], gpa[29:0]}. An entry at level 2 with bit 7 set ends the walk as a 2 MB leaf, with result {entry[PA_W-1:21], gpa[20:0]}. In both cases no further read is issued.
- R4: Bit 7 has no effect at level 1 or at any level above 3. Such an entry is handled exactly as if the bit were clear.
- R5: An entry whose bits [2:0] are all zero is not present.
  - It ends the walk with a violation at that level, with no further reads.
  - The reported permission field is 000.
- R6: The access kind `req_kind` needs one bit of the effective permission, which is the AND of bits [2:0] over all visited entries:
  - code 0 (read) needs bit 0;
  - code 1 (write) needs bit 1;
  - code 2 (fetch) needs bit 2.
  A leaf whose effective permission lacks the needed bit raises a violation at the leaf level.
- R7: An execute-only leaf (bits [2:0] = 100) allows a fetch and makes a read or a write fault.
- R8: A violation sets `done_fault` and reports:
  - `flt_kind`, one-hot with bit 0 = read, bit 1 = write, bit 2 = fetch;
  - the full guest address on `flt_gpa`;
  - the level on `flt_level`;
  - the effective permission on `flt_perm`;
  - `done_hpa` = 0.
  A successful walk sets all fault fields to zero.
- R9: Only one table read is outstanding at a time.
  - `rd_valid` is a one-cycle pulse, and the next read waits for the response.
  - `req_ready` is high only when the block is idle, and `req_valid` while busy is ignored.
  - `done` is a one-cycle pulse followed by the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_gpa | input | 12+9*LEVELS | Guest physical address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| root_base | input | PA_W | Root table address (low 12 bits ignored) |
| req_ready | output | 1 | Block is idle |
| rd_valid | output | 1 | Table read request |
| rd_addr | output | PA_W | Byte address of the 64-bit entry to read |
| rsp_valid | input | 1 | Table read data valid |
| rsp_data | input | 64 | Entry returned by the table read |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk ended in a violation |
| done_hpa | output | PA_W | Translated host physical address |
| flt_kind | output | 3 | One-hot access kind of the violation |
| flt_gpa | output | 12+9*LEVELS | Faulting guest physical address |
| flt_level | output | 3 | Level at which the violation was found |
| flt_perm | output | 3 | Effective permission at the violation |

## Verification
The bench builds the block with `LEVELS` = 4 and `PA_W` = 32. With those values every table page sits inside a small behavioural memory, and a guest address is four 9-bit indices plus an offset.

That small shape makes an exhaustive sweep affordable. It covers every access kind, every leaf level (4 KB, 2 MB, 1 GB) and all 64 pairs of root-entry and leaf-entry permission bits. For each walk the bench computes the expected result address, the fault record and the number of reads.

Directed walks add:
- stray page-size bits at the root and at level 1;
- execute-only pages;
- requests pushed in while a walk is busy.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int ENTRY_W = 64;
  localparam int IDX_W   = 9;
  localparam int PAGE_SH = 12;
  localparam int PS_BIT  = 7;
  localparam int LVL_W   = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walk_st_e;

endpackage

// File: rtl/ptw_index.sv
module ptw_index
  import ptw_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int PA_W   = 52
) (
  input  logic [PA_W-PAGE_SH-1:0]   frame,
  input  logic [IDX_W*LEVELS-1:0]   gpa_hi,
  input  logic [LVL_W-1:0]          level,
  output logic [PA_W-1:0]           addr
);

  logic [IDX_W-1:0] idx_of [LEVELS];
  logic [IDX_W-1:0] idx;

  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign idx_of[g] = gpa_hi[g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (level == LVL_W'(l + 1)) idx = idx_of[l];
    end
  end

  assign addr = {frame, idx, 3'b000};

endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
  import ptw_pkg::*;
#(
  parameter int PA_W = 52
) (
  input  logic [ENTRY_W-1:0]      entry,
  input  logic [LVL_W-1:0]        level,
  input  logic [29:0]             gpa_lo,
  input  logic [2:0]              perm_in,
  output logic                    present,
  output logic                    leaf,
  output logic [2:0]              perm_out,
  output logic [PA_W-PAGE_SH-1:0] next_frame,
  output logic [PA_W-1:0]         leaf_hpa
);

  logic [PA_W-1:0] ent_addr;
  logic [PA_W-1:0] off_ext;
  logic [PA_W-1:0] lo_mask;
  logic            ps;
  logic            large_ok;
  int              sh;
  logic            unused_entry_bits;

  assign unused_entry_bits = ^{entry[ENTRY_W-1:PA_W], entry[11:8], entry[6:3]};

  assign present    = |entry[2:0];
  assign perm_out   = perm_in & entry[2:0];
  assign ps         = entry[PS_BIT];
  assign large_ok   = (level == 3'd2) || (level == 3'd3);
  assign leaf       = (level == 3'd1) || (ps && large_ok);
  assign next_frame = entry[PA_W-1:PAGE_SH];
  assign ent_addr   = {entry[PA_W-1:PAGE_SH], {PAGE_SH{1'b0}}};
  assign off_ext    = {{(PA_W-30){1'b0}}, gpa_lo};

  always_comb begin
    unique case (level)
      3'd2:    sh = PAGE_SH + IDX_W;
      3'd3:    sh = PAGE_SH + 2 * IDX_W;
      default: sh = PAGE_SH;
    endcase
  end

  assign lo_mask  = (PA_W'(1) << sh) - PA_W'(1);
  assign leaf_hpa = (ent_addr & ~lo_mask) | (off_ext & lo_mask);

endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  logic [1:0] kind,
  input  logic [2:0] perm,
  output logic [2:0] need,
  output logic       allowed
);

  always_comb begin
    unique case (acc_kind_e'(kind))
      ACC_WRITE: need = 3'b010;
      ACC_FETCH: need = 3'b100;
      default:   need = 3'b001;
    endcase
  end

  assign allowed = |(need & perm);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int PA_W   = 52
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [12+9*LEVELS-1:0]    req_gpa,
  input  logic [1:0]                req_kind,
  input  logic [PA_W-1:0]           root_base,
  output logic                      req_ready,
  output logic                      rd_valid,
  output logic [PA_W-1:0]           rd_addr,
  input  logic                      rsp_valid,
  input  logic [63:0]               rsp_data,
  output logic                      done,
  output logic                      done_fault,
  output logic [PA_W-1:0]           done_hpa,
  output logic [2:0]                flt_kind,
  output logic [12+9*LEVELS-1:0]    flt_gpa,
  output logic [2:0]                flt_level,
  output logic [2:0]                flt_perm
);

  localparam int GPA_W = PAGE_SH + IDX_W * LEVELS;
  localparam int FRM_W = PA_W - PAGE_SH;

  // walk state
  walk_st_e          st_q, st_d;
  logic [GPA_W-1:0]  gpa_q, gpa_d;
  logic [1:0]        kind_q, kind_d;
  logic [FRM_W-1:0]  frame_q, frame_d;
  logic [LVL_W-1:0]  level_q, level_d;
  logic [2:0]        perm_q, perm_d;
  logic              walk_en;

  // result record
  logic              r_fault_q, r_fault_d;
  logic [PA_W-1:0]   r_hpa_q, r_hpa_d;
  logic [2:0]        r_kind_q, r_kind_d;
  logic [GPA_W-1:0]  r_gpa_q, r_gpa_d;
  logic [LVL_W-1:0]  r_level_q, r_level_d;
  logic [2:0]        r_perm_q, r_perm_d;
  logic              res_en;

  // entry evaluation
  logic              ev_present, ev_leaf;
  logic [2:0]        ev_perm;
  logic [FRM_W-1:0]  ev_next;
  logic [PA_W-1:0]   ev_hpa;
  logic [2:0]        acc_need;
  logic              acc_allowed;
  logic              unused_root_lo;

  assign unused_root_lo = ^root_base[PAGE_SH-1:0];

  ptw_index #(.LEVELS(LEVELS), .PA_W(PA_W)) i_index (
    .frame  (frame_q),
    .gpa_hi (gpa_q[GPA_W-1:PAGE_SH]),
    .level  (level_q),
    .addr   (rd_addr)
  );

  ptw_entry_eval #(.PA_W(PA_W)) i_eval (
    .entry      (rsp_data),
    .level      (level_q),
    .gpa_lo     (gpa_q[29:0]),
    .perm_in    (perm_q),
    .present    (ev_present),
    .leaf       (ev_leaf),
    .perm_out   (ev_perm),
    .next_frame (ev_next),
    .leaf_hpa   (ev_hpa)
  );

  ptw_perm_check i_perm (
    .kind    (kind_q),
    .perm    (ev_perm),
    .need    (acc_need),
    .allowed (acc_allowed)
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    gpa_d     = gpa_q;
    kind_d    = kind_q;
    frame_d   = frame_q;
    level_d   = level_q;
    perm_d    = perm_q;
    walk_en   = 1'b0;
    res_en    = 1'b0;
    r_fault_d = 1'b0;
    r_hpa_d   = '0;
    r_kind_d  = '0;
    r_gpa_d   = '0;
    r_level_d = '0;
    r_perm_d  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          walk_en = 1'b1;
          st_d    = ST_ISSUE;
          gpa_d   = req_gpa;
          kind_d  = req_kind;
          frame_d = root_base[PA_W-1:PAGE_SH];
          level_d = LVL_W'(LEVELS);
          perm_d  = 3'b111;
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (rsp_valid) begin
          walk_en = 1'b1;
          perm_d  = ev_perm;
          if (!ev_present || ev_leaf) begin
            res_en = 1'b1;
            st_d   = ST_DONE;
            if (!ev_present || !acc_allowed) begin
              r_fault_d = 1'b1;
              r_kind_d  = acc_need;
              r_gpa_d   = gpa_q;
              r_level_d = level_q;
              r_perm_d  = ev_perm;
            end else begin
              r_hpa_d = ev_hpa;
            end
          end else begin
            frame_d = ev_next;
            level_d = level_q - LVL_W'(1);
            st_d    = ST_ISSUE;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpa_q   <= '0;
      kind_q  <= '0;
      frame_q <= '0;
      level_q <= '0;
      perm_q  <= '0;
    end else if (walk_en) begin
      gpa_q   <= gpa_d;
      kind_q  <= kind_d;
      frame_q <= frame_d;
      level_q <= level_d;
      perm_q  <= perm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_fault_q <= 1'b0;
      r_hpa_q   <= '0;
      r_kind_q  <= '0;
      r_gpa_q   <= '0;
      r_level_q <= '0;
      r_perm_q  <= '0;
    end else if (res_en) begin
      r_fault_q <= r_fault_d;
      r_hpa_q   <= r_hpa_d;
      r_kind_q  <= r_kind_d;
      r_gpa_q   <= r_gpa_d;
      r_level_q <= r_level_d;
      r_perm_q  <= r_perm_d;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign rd_valid   = (st_q == ST_ISSUE);
  assign done       = (st_q == ST_DONE);
  assign done_fault = r_fault_q;
  assign done_hpa   = r_hpa_q;
  assign flt_kind   = r_kind_q;
  assign flt_gpa    = r_gpa_q;
  assign flt_level  = r_level_q;
  assign flt_perm   = r_perm_q;

  // checks on the walk protocol
  assert_accept_issues_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rd_valid && !req_ready));

  assert_single_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  assert_fault_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault) |-> ($countones(flt_kind) == 1));

  assert_level_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (level_q >= 3'd1 && level_q <= LVL_W'(LEVELS)));

  assert_success_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_fault) |-> (flt_kind == 3'b000 && flt_level == 3'd0));

endmodule

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;

  localparam int LEVELS = 4;
  localparam int PA_W   = 32;
  localparam int GPA_W  = 12 + 9 * LEVELS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [GPA_W-1:0]  req_gpa = '0;
  logic [1:0]        req_kind = '0;
  logic [PA_W-1:0]   root_base = 32'h0000_1000;
  logic              req_ready, rd_valid, rsp_valid, done, done_fault;
  logic [PA_W-1:0]   rd_addr, done_hpa;
  logic [63:0]       rsp_data;
  logic [2:0]        flt_kind, flt_level, flt_perm;
  logic [GPA_W-1:0]  flt_gpa;

  always #2 clk = ~clk;

  ptw_walker #(.LEVELS(LEVELS), .PA_W(PA_W)) i_ptw_walker (
    .clk, .rst_n, .req_valid, .req_gpa, .req_kind, .root_base, .req_ready,
    .rd_valid, .rd_addr, .rsp_valid, .rsp_data, .done, .done_fault, .done_hpa,
    .flt_kind, .flt_gpa, .flt_level, .flt_perm
  );

  // behavioural table memory: 16 pages of 512 entries
  logic [63:0] tmem [0:8191];
  int reads_total = 0;

  always @(posedge clk) begin
    rsp_valid <= rd_valid;
    rsp_data  <= tmem[rd_addr[15:3]];
    if (rd_valid) reads_total <= reads_total + 1;
  end

  int nchk = 0;
  int nerr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [31:0] a, input logic ps, input logic [2:0] p);
    logic [63:0] e;
    e = '0;
    e[31:12] = a[31:12];
    e[7] = ps;
    e[2:0] = p;
    return e;
  endfunction

  // expected outcome of the prepared walk
  logic [GPA_W-1:0] e_gpa;
  logic [1:0]       e_kindc;
  logic             e_fault;
  logic [PA_W-1:0]  e_hpa;
  logic [2:0]       e_kind, e_level, e_perm;
  int               e_reads;
  string            e_tag;

  // results of the last walk
  logic             g_fault, g_seen;
  logic [PA_W-1:0]  g_hpa;
  logic [2:0]       g_kind, g_level, g_perm;
  logic [GPA_W-1:0] g_gpa;
  int               g_reads;

  task automatic prep(input int n, input int lv, input logic [2:0] rootp,
                      input logic [2:0] leafp, input logic root_ps,
                      input logic low_ps, input logic [1:0] k);
    logic [8:0]  i4, i3, i2, i1;
    logic [11:0] off;
    logic [31:0] f1, b2, b3;
    logic [2:0]  eff, need;
    i4  = 9'((n * 7) % 512);
    i3  = 9'((n * 13 + 5) % 512);
    i2  = 9'((n * 29 + 1) % 512);
    i1  = 9'((n * 31 + 3) % 512);
    off = 12'((n * 97) % 4096);
    f1  = 32'h1234_5000 + 32'(n << 12);
    b2  = 32'h8000_0000 + 32'(n << 21) + 32'h0001_5000;
    b3  = 32'h4000_0000 * 32'(n % 4) + 32'h0ABC_D000;
    e_gpa   = {i4, i3, i2, i1, off};
    e_kindc = k;
    tmem[512 * 1 + int'(i4)] = mk(32'h0000_2000, root_ps, rootp);
    tmem[512 * 2 + int'(i3)] = (lv == 3) ? mk(b3, 1'b1, leafp) : mk(32'h0000_3000, 1'b0, 3'b111);
    if (lv <= 2)
      tmem[512 * 3 + int'(i2)] = (lv == 2) ? mk(b2, 1'b1, leafp) : mk(32'h0000_4000, 1'b0, 3'b111);
    if (lv == 1)
      tmem[512 * 4 + int'(i1)] = mk(f1, low_ps, leafp);
    need = 3'b001 << k;
    eff  = rootp & leafp;
    e_hpa = '0; e_kind = '0; e_level = '0; e_perm = '0; e_fault = 1'b0;
    if (rootp == 3'b000) begin
      e_fault = 1'b1; e_level = 3'd4; e_reads = 1; e_tag = "R5";
    end else if (leafp == 3'b000) begin
      e_fault = 1'b1; e_level = 3'(lv); e_reads = 5 - lv; e_tag = "R5";
    end else if ((eff & need) == 3'b000) begin
      e_fault = 1'b1; e_level = 3'(lv); e_perm = eff; e_reads = 5 - lv; e_tag = "R6";
    end else begin
      e_reads = 5 - lv;
      e_tag = (lv == 1) ? "R2" : "R3";
      if (lv == 3)      e_hpa = {b3[31:30], e_gpa[29:0]};
      else if (lv == 2) e_hpa = {b2[31:21], e_gpa[20:0]};
      else              e_hpa = {f1[31:12], off};
    end
    if (e_fault) e_kind = need;
  endtask

  task automatic wait_done();
    int cyc;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    g_seen  = done;
    g_fault = done_fault;
    g_hpa   = done_hpa;
    g_kind  = flt_kind;
    g_level = flt_level;
    g_perm  = flt_perm;
    g_gpa   = flt_gpa;
  endtask

  task automatic walk();
    int r0;
    @(negedge clk);
    r0 = reads_total;
    req_valid = 1'b1;
    req_gpa   = e_gpa;
    req_kind  = e_kindc;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    g_reads = reads_total - r0;
  endtask

  task automatic verify(input string tag);
    chk(g_seen == 1'b1, "R9", "done seen", 64'(g_seen), 64'd1);
    chk(g_fault == e_fault, tag, "fault flag", 64'(g_fault), 64'(e_fault));
    chk(g_hpa == e_hpa, tag, "hpa", 64'(g_hpa), 64'(e_hpa));
    chk(g_reads == e_reads, tag, "read count", 64'(g_reads), 64'(e_reads));
    chk({g_kind, g_level, g_perm} == {e_kind, e_level, e_perm}, "R8", "kind/level/perm",
        64'({g_kind, g_level, g_perm}), 64'({e_kind, e_level, e_perm}));
    chk(g_gpa == (e_fault ? e_gpa : '0), "R8", "fault gpa",
        64'(g_gpa), 64'(e_fault ? e_gpa : '0));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL R9 watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int n;
    for (int a = 0; a < 8192; a++) tmem[a] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready === 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk({req_ready, rd_valid, done} === 3'b100, "R1", "ready/rd/done after reset",
        64'({req_ready, rd_valid, done}), 64'b100);

    // exhaustive sweep: kinds x leaf levels x root perm x leaf perm (R2 R3 R5 R6 R8)
    n = 0;
    for (int k = 0; k < 3; k++) begin
      for (int lv = 1; lv <= 3; lv++) begin
        for (int rp = 0; rp < 8; rp++) begin
          for (int lp = 0; lp < 8; lp++) begin
            prep(n, lv, 3'(rp), 3'(lp), 1'b0, 1'b0, 2'(k));
            walk();
            verify(e_tag);
            n++;
          end
        end
      end
    end

    // R4: page-size bit at root and at level 1 has no effect
    prep(700, 1, 3'b111, 3'b011, 1'b1, 1'b1, 2'd1);
    walk();
    verify("R4");

    // R7: execute-only leaf, fetch succeeds, read and write fault
    prep(701, 1, 3'b111, 3'b100, 1'b0, 1'b0, 2'd2);
    walk();
    verify("R7");
    chk(g_fault == 1'b0, "R7", "fetch of exec-only", 64'(g_fault), 64'd0);
    prep(702, 1, 3'b111, 3'b100, 1'b0, 1'b0, 2'd0);
    walk();
    verify("R7");
    chk(g_fault == 1'b1 && g_kind == 3'b001, "R7", "read of exec-only",
        64'({g_fault, g_kind}), 64'({1'b1, 3'b001}));
    prep(703, 2, 3'b111, 3'b100, 1'b0, 1'b0, 2'd1);
    walk();
    verify("R7");

    // R9: requests while busy are ignored; done is a single pulse
    prep(704, 1, 3'b111, 3'b111, 1'b0, 1'b0, 2'd0);
    begin
      int r0;
      @(negedge clk);
      r0 = reads_total;
      req_valid = 1'b1;
      req_gpa   = e_gpa;
      req_kind  = e_kindc;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        req_gpa  = ~e_gpa;
        req_kind = 2'd2;
        chk(req_ready == 1'b0, "R9", "ready low while busy", 64'(req_ready), 64'd0);
      end
      req_valid = 1'b0;
      wait_done();
      g_reads = reads_total - r0;
    end
    verify("R9");
    @(negedge clk);
    chk({done, req_ready} == 2'b01, "R9", "done pulse then idle",
        64'({done, req_ready}), 64'b01);
    chk(rd_valid == 1'b0, "R9", "no read after done", 64'(rd_valid), 64'd0);

    summary();
    $finish;
  end

endmodule